// File: doc/BRIEF.md
# Paged Edge-Detect Digital I/O Bank

This block is a bank of open-drain digital lines, eight per port byte, with edge-detect interrupts on every line. Software reaches it through a small byte-wide register window. The port bytes can be reached at any time. A second group of byte addresses is banked by a page register, so that the same three addresses hold the edge-polarity bytes, the edge-enable bytes or the latched edge-identification bytes, depending on the page.

A port bit written as 1 makes its line sink current. A bit written as 0 releases the line, and an external pull-up then holds it high. A read of a port returns the inverted line level, taken after a two-flop synchroniser. The synchronised sample is compared with the sample from the cycle before. An edge of the chosen direction on an enabled bit is latched into the identification byte. A pending summary register holds the OR of each identification byte, and an interrupt line holds the OR of the whole summary. Each port byte also has a lock bit that blocks writes to it.

Top module: `edio_bank`

## Requirements
- R1: Port byte n sits at offset 0x10+n. Writes to it and reads of it work on every page. A 1 written to a port bit drives the matching `pin_sink` bit to 1.
- R2: A read of port byte n returns the inverse of the line levels. The value reflects a change on `pin_in` from the second rising clock edge after the change.
- R3: Offset 0x17 holds the page in bits 7:6 and the lock bits in bits 5:0 (bit n locks port n), and reads back what was written.
- R4: Offsets 0x18+n select a different register by page. Page 1 selects polarity byte n, page 2 selects enable byte n and page 3 selects identification byte n. On page 0 these addresses read 0, and writes to them change nothing.
- R5: A polarity bit of 1 selects rising edges and a polarity bit of 0 selects falling edges. A qualifying line change shows in the identification byte and on `irq` after the third rising clock edge, and not after the second.
- R6: An identification bit can become set only while its enable bit is 1.
- R7: A write to identification byte n keeps only the bits written as 1, so writing 0 clears the byte. An edge detected in the same cycle as that write is still latched.
- R8: Offset 0x16 bit n is the OR of identification byte n, and the higher bits read 0. `irq` is 1 exactly when some identification bit is set.
- R9: While lock bit n is set, writes to port byte n are ignored.
- R10: Reset clears the port bytes, the page, the lock bits, and the polarity, enable and identification bytes, and holds `irq` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 5 | Register offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| pin_in | input | 8*NUM_PORTS | Sensed line levels |
| pin_sink | output | 8*NUM_PORTS | 1 = sink the line low, 0 = release it |
| irq | output | 1 | Interrupt request, OR of all pending bits |

## Verification
The bench builds the block with the default of three port bytes. With three bytes every address in the window can be used: the three port offsets, the summary register, the page/lock register and all three paged bytes on every page. The three bytes also let the bench check the summary register with two port bytes pending at the same time. The bench models the open-drain lines by combining `pin_sink` with its own pull-down vector. This lets it set the exact edge timing, including an edge that lands in the same cycle as a clear of the identification byte.

// File: rtl/edio_pkg.sv
package edio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 8;
  localparam int LOCK_W     = 6;
  localparam int PORT_BASE  = 16;
  localparam int PEND_OFF   = 22;
  localparam int PGLK_OFF   = 23;
  localparam int PAGED_BASE = 24;

  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_EN   = 2'd2,
    PG_ID   = 2'd3
  } page_e;
endpackage

// File: rtl/edio_sync.sv
module edio_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;
  logic [W-1:0] cur_q;
  logic [W-1:0] prev_q;

  // idle level of a pulled-up line is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      cur_q  <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= pin_in;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;
endmodule

// File: rtl/edio_byte_ctl.sv
module edio_byte_ctl #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pol_we,
  input  logic          en_we,
  input  logic          id_we,
  input  logic [BW-1:0] wdata,
  input  logic [BW-1:0] cur,
  input  logic [BW-1:0] prev,
  output logic [BW-1:0] pol_q,
  output logic [BW-1:0] en_q,
  output logic [BW-1:0] id_q
);
  logic [BW-1:0] rise, fall, det;
  logic [BW-1:0] pol_nxt, en_nxt, id_nxt;

  always_comb begin
    rise    = cur & ~prev;
    fall    = ~cur & prev;
    det     = en_q & ((pol_q & rise) | (~pol_q & fall));
    pol_nxt = pol_we ? wdata : pol_q;
    en_nxt  = en_we ? wdata : en_q;
    // set dominates the software clear
    id_nxt  = (id_we ? (id_q & wdata) : id_q) | det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
      en_q  <= '0;
      id_q  <= '0;
    end else begin
      pol_q <= pol_nxt;
      en_q  <= en_nxt;
      id_q  <= id_nxt;
    end
  end

  p_id_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((id_q & ~$past(id_q) & ~$past(en_q)) == '0));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_we && wdata == '0) |=> (id_q == $past(det)));

  p_rise_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_q & pol_q & cur & ~prev)) |=> (|id_q));
endmodule

// File: rtl/edio_bank.sv
module edio_bank
  import edio_pkg::*;
#(
  parameter int NUM_PORTS = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [4:0]                  addr,
  input  logic [7:0]                  wdata,
  output logic [7:0]                  rdata,
  input  logic [NUM_PORTS*8-1:0]      pin_in,
  output logic [NUM_PORTS*8-1:0]      pin_sink,
  output logic                        irq
);
  localparam int PIN_W = NUM_PORTS * DATA_W;

  logic [PIN_W-1:0]  cur, prev;
  logic [PIN_W-1:0]  out_q, out_nxt;
  logic [PIN_W-1:0]  pol_all, en_all, id_all;
  logic [DATA_W-1:0] pgl_q, pgl_nxt;
  logic [NUM_PORTS-1:0] pend;
  page_e             page;

  assign page = page_e'(pgl_q[7:6]);

  edio_sync #(.W(PIN_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cur(cur), .prev(prev)
  );

  // page / lock register
  always_comb begin
    pgl_nxt = pgl_q;
    if (wr_en && addr == ADDR_W'(PGLK_OFF)) pgl_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgl_q <= '0;
    else        pgl_q <= pgl_nxt;
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    localparam logic [ADDR_W-1:0] PORT_A  = ADDR_W'(PORT_BASE + g);
    localparam logic [ADDR_W-1:0] PAGED_A = ADDR_W'(PAGED_BASE + g);
    logic port_we, paged_hit;

    assign port_we   = wr_en && addr == PORT_A && !pgl_q[g];
    assign paged_hit = wr_en && addr == PAGED_A;

    always_comb begin
      out_nxt[g*DATA_W +: DATA_W] = out_q[g*DATA_W +: DATA_W];
      if (port_we) out_nxt[g*DATA_W +: DATA_W] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q[g*DATA_W +: DATA_W] <= '0;
      else        out_q[g*DATA_W +: DATA_W] <= out_nxt[g*DATA_W +: DATA_W];
    end

    edio_byte_ctl #(.BW(DATA_W)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .pol_we(paged_hit && page == PG_POL),
      .en_we (paged_hit && page == PG_EN),
      .id_we (paged_hit && page == PG_ID),
      .wdata (wdata),
      .cur   (cur[g*DATA_W +: DATA_W]),
      .prev  (prev[g*DATA_W +: DATA_W]),
      .pol_q (pol_all[g*DATA_W +: DATA_W]),
      .en_q  (en_all[g*DATA_W +: DATA_W]),
      .id_q  (id_all[g*DATA_W +: DATA_W])
    );

    assign pend[g] = |id_all[g*DATA_W +: DATA_W];

    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == PORT_A && pgl_q[g]) |=> $stable(pin_sink[g*DATA_W +: DATA_W]));
  end

  assign pin_sink = out_q;
  assign irq      = |pend;

  // read mux
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (addr == ADDR_W'(PORT_BASE + i)) rdata = ~cur[i*DATA_W +: DATA_W];
      if (addr == ADDR_W'(PAGED_BASE + i)) begin
        case (page)
          PG_POL:  rdata = pol_all[i*DATA_W +: DATA_W];
          PG_EN:   rdata = en_all[i*DATA_W +: DATA_W];
          PG_ID:   rdata = id_all[i*DATA_W +: DATA_W];
          default: rdata = '0;
        endcase
      end
    end
    if (addr == ADDR_W'(PEND_OFF)) rdata = DATA_W'(pend);
    if (addr == ADDR_W'(PGLK_OFF)) rdata = pgl_q;
  end

  p_irq_any_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (id_all != '0));

  p_page0_inert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && page == PG_NONE && addr >= ADDR_W'(PAGED_BASE)
     && addr < ADDR_W'(PAGED_BASE + NUM_PORTS))
    |=> ($stable(pol_all) && $stable(en_all)));

  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq && pin_sink == '0 && pgl_q == '0));
endmodule

// File: tb/tb_edio_bank.sv
module tb_edio_bank;
  localparam int NP = 3;
  localparam int PW = NP * 8;
  localparam int NV = 30;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [4:0]    addr;
  logic [7:0]    wdata;
  logic [7:0]    rdata;
  logic [PW-1:0] pin_in;
  logic [PW-1:0] pin_sink;
  logic          irq;
  logic [PW-1:0] ext_low;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  // open-drain line: low if the block or the bench pulls it down
  assign pin_in = ~(pin_sink | ext_low);

  edio_bank #(.NUM_PORTS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_sink(pin_sink), .irq(irq)
  );

  // {write, offset, data, expected read}
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 5'h17, 8'h40, 8'h00}, {1'b0, 5'h17, 8'h00, 8'h40},
    {1'b1, 5'h18, 8'hA5, 8'h00}, {1'b0, 5'h18, 8'h00, 8'hA5},
    {1'b1, 5'h17, 8'h80, 8'h00}, {1'b0, 5'h18, 8'h00, 8'h00},
    {1'b1, 5'h19, 8'h3C, 8'h00}, {1'b0, 5'h19, 8'h00, 8'h3C},
    {1'b1, 5'h17, 8'h40, 8'h00}, {1'b0, 5'h18, 8'h00, 8'hA5},
    {1'b0, 5'h19, 8'h00, 8'h00}, {1'b1, 5'h17, 8'h00, 8'h00},
    {1'b1, 5'h18, 8'hFF, 8'h00}, {1'b0, 5'h18, 8'h00, 8'h00},
    {1'b1, 5'h17, 8'h40, 8'h00}, {1'b0, 5'h18, 8'h00, 8'hA5},
    {1'b1, 5'h10, 8'h0F, 8'h00}, {1'b0, 5'h10, 8'h00, 8'h0F},
    {1'b1, 5'h17, 8'hC1, 8'h00}, {1'b0, 5'h17, 8'h00, 8'hC1},
    {1'b1, 5'h10, 8'hF0, 8'h00}, {1'b0, 5'h10, 8'h00, 8'h0F},
    {1'b1, 5'h11, 8'h81, 8'h00}, {1'b0, 5'h11, 8'h00, 8'h81},
    {1'b1, 5'h17, 8'h00, 8'h00}, {1'b1, 5'h10, 8'h00, 8'h00},
    {1'b0, 5'h10, 8'h00, 8'h00}, {1'b1, 5'h11, 8'h00, 8'h00},
    {1'b0, 5'h11, 8'h00, 8'h00}, {1'b0, 5'h16, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(req, {24'h0, rdata}, {24'h0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; ext_low = '0;
    do_reset();

    // R10 reset state
    chk("R10 pin_sink", {8'h0, pin_sink}, 32'h0);
    chk("R10 irq", {31'h0, irq}, 32'h0);
    rd("R10 page/lock", 5'h17, 8'h00);
    rd("R10 pending", 5'h16, 8'h00);
    rd("R2 idle lines read 0", 5'h10, 8'h00);

    // table walk: R1 R3 R4 R9
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) begin
        wr(VEC[i][20:16], VEC[i][15:8]);
        repeat (3) @(negedge clk);
      end else begin
        rd($sformatf("R1 R3 R4 R9 vector %0d", i), VEC[i][20:16], VEC[i][7:0]);
      end
    end

    // R10 from dirty state
    wr(5'h10, 8'h55);
    wr(5'h17, 8'h7F);
    do_reset();
    chk("R10 ports cleared", {8'h0, pin_sink}, 32'h0);
    rd("R10 page/lock cleared", 5'h17, 8'h00);
    wr(5'h17, 8'h40);
    rd("R10 polarity cleared", 5'h18, 8'h00);
    wr(5'h17, 8'h80);
    rd("R10 enable cleared", 5'h19, 8'h00);

    // R2 read inversion and latency
    @(negedge clk);
    ext_low[20] = 1'b1;
    @(negedge clk);
    rd("R2 one edge later unchanged", 5'h12, 8'h00);
    @(negedge clk);
    rd("R2 two edges later inverted", 5'h12, 8'h10);
    ext_low[20] = 1'b0;
    repeat (3) @(negedge clk);

    // R5 R6: byte0 enables bits 1:0, bit0 rising, bit1 falling
    wr(5'h18, 8'h03);
    wr(5'h17, 8'h40);
    wr(5'h18, 8'h01);
    wr(5'h17, 8'hC0);
    @(negedge clk);
    ext_low[2:0] = 3'b111;
    repeat (4) @(negedge clk);
    rd("R5 R6 falling on bit1 only", 5'h18, 8'h02);
    chk("R8 irq set", {31'h0, irq}, 32'h1);
    rd("R8 pending byte0", 5'h16, 8'h01);
    ext_low[0] = 1'b0;
    repeat (4) @(negedge clk);
    rd("R5 rising on bit0", 5'h18, 8'h03);

    // R7 clear by zero write
    wr(5'h18, 8'h00);
    rd("R7 cleared", 5'h18, 8'h00);
    chk("R8 irq cleared", {31'h0, irq}, 32'h0);

    // R5 latency: visible after third edge, not second
    ext_low[0] = 1'b1;
    ext_low[1] = 1'b0;
    repeat (4) @(negedge clk);
    wr(5'h18, 8'h00);
    chk("R5 quiet before edge", {31'h0, irq}, 32'h0);
    ext_low[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R5 not after two edges", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R5 set after three edges", {31'h0, irq}, 32'h1);
    wr(5'h18, 8'hFF);
    rd("R7 ones keep bits", 5'h18, 8'h02);

    // R7 set wins over clear in the same cycle
    ext_low[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'h18; wdata = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    rd("R7 set wins", 5'h18, 8'h01);

    // R8 two bytes pending; R6 bit not enabled stays clear
    wr(5'h17, 8'h80);
    wr(5'h19, 8'h08);
    wr(5'h17, 8'hC0);
    @(negedge clk);
    ext_low[11] = 1'b1;
    ext_low[12] = 1'b1;
    repeat (4) @(negedge clk);
    rd("R6 R8 byte1 id", 5'h19, 8'h08);
    rd("R8 pending two bytes", 5'h16, 8'h03);
    wr(5'h18, 8'h00);
    wr(5'h19, 8'h00);
    rd("R8 pending cleared", 5'h16, 8'h00);
    chk("R8 irq low", {31'h0, irq}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule